// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Bypass Path

This block is the serial test port controller of a device. It is clocked by the test clock `tck` and steered by the mode-select input `tms`. It walks a sixteen-state controller, and during the shift states it moves serial data from `tdi` to `tdo`. The serial path goes through either an instruction register or a data register.

The instruction register is eight bits wide. It has a shift stage and a separate held stage. The held stage, called the current instruction, is loaded only in the update step. When the current instruction is all ones, a single-bit bypass stage is selected. Any other value selects a user data register whose width is a parameter. That register is parallel-loaded from its own held value during capture, so software can read back and rewrite it.

Inputs and captures are taken on the rising edge of `tck`. Serial output, the output enable and every held-register update change on the falling edge. A real pad's three-state buffer is represented here only by the `tdo_oe` output.

Top module: `tap_bypass_top`

## Requirements
- R1: On each rising `tck` edge the controller moves to the next state chosen by `tms`, following the standard sixteen-state test controller graph. The state is reported on `tap_state_o` with this encoding: reset 0, idle 1, select-DR 2, capture-DR 3, shift-DR 4, exit1-DR 5, pause-DR 6, exit2-DR 7, update-DR 8, select-IR 9, capture-IR 10, shift-IR 11, exit1-IR 12, pause-IR 13, exit2-IR 14, update-IR 15.
- R2: `trst` is a synchronous active-high reset. A rising edge with `trst` high puts the controller in state 0. The falling edge that follows sets `ir_q` to 8'hFF and `user_q` to 0, and drives `tdo_oe` and `tdo` to 0.
- R3: Five consecutive rising edges with `tms` high bring the controller to state 0 from any state.
- R4: Leaving capture-IR loads the instruction shift stage with 8'b10000001. Each rising edge in shift-IR moves `tdi` into bit 7 and shifts the stage toward bit 0. Bit 0 is the serial output.
- R5: `ir_q` takes the shift-stage value on the falling edge while in update-IR. It becomes 8'hFF on any falling edge while in state 0. It does not change at any other time.
- R6: With `ir_q` all ones, leaving capture-DR loads the one-bit bypass stage with 0, and shift-DR delays `tdi` by one stage. Shifting in 1,0,1 therefore gives 0,1,0 on `tdo`.
- R7: With any other `ir_q`, capture-DR loads the user shift stage from `user_q`. Shift-DR moves `tdi` into the top bit, and bit 0 is the serial output. The falling edge in update-DR copies the stage into `user_q`. While bypass is selected, update-DR leaves `user_q` unchanged.
- R8: `tdo_oe` is set on the falling edge in shift-IR or shift-DR, and cleared on every other falling edge, including in the exit and pause states. While it is set, `tdo` shows bit 0 of the selected shift path.
- R9: `tdo` is 0 whenever `tdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst | input | 1 | Synchronous active-high controller reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` |
| tap_state_o | output | 4 | Current controller state (encoding in R1) |
| ir_q | output | IR_W | Current instruction |
| user_q | output | DR_W | Held value of the user data register |

## Verification
The embedded properties check these rules on every cycle:
- reset entry and the run of five high `tms` edges;
- a few fixed transitions;
- the capture constants of both the instruction and bypass stages;
- that `tdo_oe` is never set outside the shift states and that `tdo` stays low while disabled;
- that `user_q` is stable outside update-DR.

Only the bench scenarios can show the serial content. That covers the 10000001 pattern seen on `tdo` and the 010 response of the bypass path. It also covers write-then-readback of the user register across a pause, the `user_q` value being left alone under bypass, and reset taking effect in the middle of a shift. Throughout these scenarios a behavioural model is compared against the outputs after every falling edge.

// File: rtl/tap_pkg.sv
package tap_pkg;

  localparam int STATE_W = 4;

  typedef enum logic [STATE_W-1:0] {
    ST_RESET = 4'd0,
    ST_IDLE  = 4'd1,
    ST_SELDR = 4'd2,
    ST_CAPDR = 4'd3,
    ST_SHDR  = 4'd4,
    ST_EX1DR = 4'd5,
    ST_PADR  = 4'd6,
    ST_EX2DR = 4'd7,
    ST_UPDR  = 4'd8,
    ST_SELIR = 4'd9,
    ST_CAPIR = 4'd10,
    ST_SHIR  = 4'd11,
    ST_EX1IR = 4'd12,
    ST_PAIR  = 4'd13,
    ST_EX2IR = 4'd14,
    ST_UPIR  = 4'd15
  } tap_state_e;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
#(
  parameter int RESET_RUN = 5
) (
  input  logic       tck,
  input  logic       trst,
  input  logic       tms,
  output tap_state_e state
);

  localparam int CNT_W = $clog2(RESET_RUN + 1);

  tap_state_e state_nx;
  logic [CNT_W-1:0] ones_cnt;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RESET: state_nx = tms ? ST_RESET : ST_IDLE;
      ST_IDLE:  state_nx = tms ? ST_SELDR : ST_IDLE;
      ST_SELDR: state_nx = tms ? ST_SELIR : ST_CAPDR;
      ST_CAPDR: state_nx = tms ? ST_EX1DR : ST_SHDR;
      ST_SHDR:  state_nx = tms ? ST_EX1DR : ST_SHDR;
      ST_EX1DR: state_nx = tms ? ST_UPDR  : ST_PADR;
      ST_PADR:  state_nx = tms ? ST_EX2DR : ST_PADR;
      ST_EX2DR: state_nx = tms ? ST_UPDR  : ST_SHDR;
      ST_UPDR:  state_nx = tms ? ST_SELDR : ST_IDLE;
      ST_SELIR: state_nx = tms ? ST_RESET : ST_CAPIR;
      ST_CAPIR: state_nx = tms ? ST_EX1IR : ST_SHIR;
      ST_SHIR:  state_nx = tms ? ST_EX1IR : ST_SHIR;
      ST_EX1IR: state_nx = tms ? ST_UPIR  : ST_PAIR;
      ST_PAIR:  state_nx = tms ? ST_EX2IR : ST_PAIR;
      ST_EX2IR: state_nx = tms ? ST_UPIR  : ST_SHIR;
      ST_UPIR:  state_nx = tms ? ST_SELDR : ST_IDLE;
      default:  state_nx = ST_RESET;
    endcase
  end

  always_ff @(posedge tck) begin
    if (trst) state <= ST_RESET;
    else      state <= state_nx;
  end

  // saturating run length of high tms, used only by the checks below
  always_ff @(posedge tck) begin
    if (trst || !tms)                        ones_cnt <= '0;
    else if (ones_cnt != CNT_W'(RESET_RUN))  ones_cnt <= ones_cnt + 1'b1;
  end

  a_r2_trst_enters_reset: assert property (@(posedge tck)
    trst |=> state == ST_RESET);

  a_r3_five_ones_reset: assert property (@(posedge tck) disable iff (trst)
    (ones_cnt == CNT_W'(RESET_RUN)) |-> state == ST_RESET);

  a_r1_reset_to_idle: assert property (@(posedge tck) disable iff (trst)
    (state == ST_RESET && !tms) |=> state == ST_IDLE);

  a_r1_shift_dr_holds: assert property (@(posedge tck) disable iff (trst)
    (state == ST_SHDR && !tms) |=> state == ST_SHDR);

endmodule

// File: rtl/tap_ireg.sv
module tap_ireg
  import tap_pkg::*;
#(
  parameter int              IR_W       = 8,
  parameter logic [IR_W-1:0] IR_CAPTURE = 8'b1000_0001
) (
  input  logic            tck,
  input  logic            trst,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic            ir_so,
  output logic [IR_W-1:0] ir_q
);

  localparam logic [IR_W-1:0] IR_BYPASS = '1;

  logic [IR_W-1:0] ir_sh;

  // shift stage: capture and shift on rising tck
  always_ff @(posedge tck) begin
    if (state == ST_CAPIR)     ir_sh <= IR_CAPTURE;
    else if (state == ST_SHIR) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
  end

  // held instruction: changes on falling tck
  always_ff @(negedge tck) begin
    if (trst || state == ST_RESET) ir_q <= IR_BYPASS;
    else if (state == ST_UPIR)     ir_q <= ir_sh;
  end

  assign ir_so = ir_sh[0];

  a_r4_capture_pattern: assert property (@(posedge tck) disable iff (trst)
    state == ST_CAPIR |=> ir_sh == IR_CAPTURE);

  a_r5_reset_state_bypass: assert property (@(posedge tck) disable iff (trst)
    (state == ST_RESET && $past(state) == ST_RESET) |-> ir_q == IR_BYPASS);

endmodule

// File: rtl/tap_dreg.sv
module tap_dreg
  import tap_pkg::*;
#(
  parameter int IR_W = 8,
  parameter int DR_W = 8
) (
  input  logic            tck,
  input  logic            trst,
  input  logic            tdi,
  input  tap_state_e      state,
  input  logic [IR_W-1:0] ir_q,
  output logic            dr_so,
  output logic [DR_W-1:0] user_q
);

  logic            byp_sel;
  logic            byp_q;
  logic [DR_W-1:0] dr_sh;

  assign byp_sel = &ir_q;

  // bypass stage
  always_ff @(posedge tck) begin
    if (state == ST_CAPDR)     byp_q <= 1'b0;
    else if (state == ST_SHDR) byp_q <= tdi;
  end

  // user data shift stage, reads back held value on capture
  always_ff @(posedge tck) begin
    if (state == ST_CAPDR)     dr_sh <= user_q;
    else if (state == ST_SHDR) dr_sh <= {tdi, dr_sh[DR_W-1:1]};
  end

  always_ff @(negedge tck) begin
    if (trst)                               user_q <= '0;
    else if (state == ST_UPDR && !byp_sel)  user_q <= dr_sh;
  end

  assign dr_so = byp_sel ? byp_q : dr_sh[0];

  a_r6_bypass_captures_zero: assert property (@(posedge tck) disable iff (trst)
    (state == ST_CAPDR && byp_sel) |=> !byp_q);

  a_r7_user_stable: assert property (@(posedge tck) disable iff (trst)
    (!$past(trst) && state != ST_UPDR) |-> $stable(user_q));

endmodule

// File: rtl/tap_bypass_top.sv
module tap_bypass_top
  import tap_pkg::*;
#(
  parameter int              IR_W       = 8,
  parameter logic [IR_W-1:0] IR_CAPTURE = 8'b1000_0001,
  parameter int              DR_W       = 8,
  parameter int              RESET_RUN  = 5
) (
  input  logic            tck,
  input  logic            trst,
  input  logic            tms,
  input  logic            tdi,
  output logic            tdo,
  output logic            tdo_oe,
  output logic [3:0]      tap_state_o,
  output logic [IR_W-1:0] ir_q,
  output logic [DR_W-1:0] user_q
);

  tap_state_e state;
  logic       ir_so;
  logic       dr_so;

  tap_fsm #(.RESET_RUN(RESET_RUN)) u_fsm (
    .tck   (tck),
    .trst  (trst),
    .tms   (tms),
    .state (state)
  );

  tap_ireg #(.IR_W(IR_W), .IR_CAPTURE(IR_CAPTURE)) u_ir (
    .tck   (tck),
    .trst  (trst),
    .tdi   (tdi),
    .state (state),
    .ir_so (ir_so),
    .ir_q  (ir_q)
  );

  tap_dreg #(.IR_W(IR_W), .DR_W(DR_W)) u_dr (
    .tck    (tck),
    .trst   (trst),
    .tdi    (tdi),
    .state  (state),
    .ir_q   (ir_q),
    .dr_so  (dr_so),
    .user_q (user_q)
  );

  // serial output stage, falling tck
  always_ff @(negedge tck) begin
    if (trst) begin
      tdo_oe <= 1'b0;
      tdo    <= 1'b0;
    end else begin
      unique case (state)
        ST_SHIR: begin tdo_oe <= 1'b1; tdo <= ir_so; end
        ST_SHDR: begin tdo_oe <= 1'b1; tdo <= dr_so; end
        default: begin tdo_oe <= 1'b0; tdo <= 1'b0;  end
      endcase
    end
  end

  assign tap_state_o = state;

  a_r8_oe_only_shifting: assert property (@(posedge tck) disable iff (trst)
    tdo_oe |-> (state == ST_SHIR || state == ST_SHDR));

  a_r9_tdo_quiet: assert property (@(posedge tck) disable iff (trst)
    !tdo_oe |-> !tdo);

endmodule

// File: tb/tap_bypass_top_tb_top.sv
module tap_bypass_top_tb_top;

  logic       tck = 1'b0;
  logic       trst, tms, tdi;
  logic       tdo, tdo_oe;
  logic [3:0] tap_state_o;
  logic [7:0] ir_q, user_q;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 tck = ~tck;

  tap_bypass_top dut_i (
    .tck(tck), .trst(trst), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdo_oe(tdo_oe), .tap_state_o(tap_state_o),
    .ir_q(ir_q), .user_q(user_q)
  );

  // behavioural reference model
  int         ms = 0;
  logic [7:0] m_irsh = '0, m_ir = 8'hFF, m_dsh = '0, m_user = '0;
  logic       m_byp = 0, m_oe = 0, m_tdo = 0;

  function automatic int next_of(int s, logic t);
    case (s)
      0: return t ? 0 : 1;    1: return t ? 2 : 1;
      2: return t ? 9 : 3;    3: return t ? 5 : 4;
      4: return t ? 5 : 4;    5: return t ? 8 : 6;
      6: return t ? 7 : 6;    7: return t ? 8 : 4;
      8: return t ? 2 : 1;    9: return t ? 0 : 10;
      10: return t ? 12 : 11; 11: return t ? 12 : 11;
      12: return t ? 15 : 13; 13: return t ? 14 : 13;
      14: return t ? 15 : 11; default: return t ? 2 : 1;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(logic t, logic d);
    int nx;
    tms = t; tdi = d;
    @(posedge tck);
    nx = trst ? 0 : next_of(ms, t);
    if (ms == 10) m_irsh = 8'h81;
    else if (ms == 11) m_irsh = {d, m_irsh[7:1]};
    if (ms == 3) begin m_byp = 0; m_dsh = m_user; end
    else if (ms == 4) begin m_byp = d; m_dsh = {d, m_dsh[7:1]}; end
    ms = nx;
    @(negedge tck);
    if (trst || ms == 0) m_ir = 8'hFF;
    else if (ms == 15) m_ir = m_irsh;
    if (trst) m_user = '0;
    else if (ms == 8 && m_ir != 8'hFF) m_user = m_dsh;
    if (!trst && ms == 11) begin m_oe = 1; m_tdo = m_irsh[0]; end
    else if (!trst && ms == 4) begin m_oe = 1; m_tdo = (m_ir == 8'hFF) ? m_byp : m_dsh[0]; end
    else begin m_oe = 0; m_tdo = 0; end
    #3;
    chk(tap_state_o == 4'(ms), "R1", "state", tap_state_o, ms);
    chk(ir_q == m_ir, "R5", "instruction", ir_q, m_ir);
    chk(user_q == m_user, "R7", "user register", user_q, m_user);
    chk(tdo_oe == m_oe, "R8", "tdo_oe", tdo_oe, m_oe);
    chk(tdo == m_tdo, "R9", "tdo", tdo, m_tdo);
  endtask

  task automatic ir_scan(logic [7:0] v, output logic [7:0] so);
    cyc(1, 0); cyc(1, 0); cyc(0, 0); cyc(0, 0);
    so[0] = tdo;
    for (int i = 0; i < 8; i++) begin
      cyc(i == 7, v[i]);
      if (i < 7) so[i+1] = tdo;
    end
    cyc(1, 0); cyc(0, 0);
  endtask

  task automatic dr_scan(logic [7:0] v, int n, bit pause, output logic [7:0] so);
    so = '0;
    cyc(1, 0); cyc(0, 0); cyc(0, 0);
    so[0] = tdo;
    for (int i = 0; i < n; i++) begin
      cyc(i == n - 1, v[i]);
      if (i < n - 1) so[i+1] = tdo;
    end
    if (pause) begin cyc(0, 0); cyc(0, 0); cyc(1, 0); end
    cyc(1, 0); cyc(0, 0);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] so;
    trst = 1; tms = 1; tdi = 0;
    @(negedge tck); #3;
    for (int i = 0; i < 3; i++) cyc(1, 0);
    chk(tap_state_o == 0, "R2", "reset state", tap_state_o, 0);
    chk(ir_q == 8'hFF && user_q == 0, "R2", "reset regs", {ir_q, user_q}, 16'hFF00);
    chk(tdo_oe == 0, "R2", "reset oe", tdo_oe, 0);
    trst = 0;
    cyc(0, 0);

    ir_scan(8'hFF, so);
    chk(so == 8'h81, "R4", "ir capture out", so, 8'h81);
    chk(ir_q == 8'hFF, "R5", "bypass loaded", ir_q, 8'hFF);

    dr_scan(8'b101, 3, 0, so);
    chk(so[2:0] == 3'b010, "R6", "bypass response", so[2:0], 3'b010);

    ir_scan(8'h05, so);
    chk(ir_q == 8'h05, "R5", "user instr", ir_q, 8'h05);
    dr_scan(8'hA5, 8, 1, so);
    chk(so == 8'h00, "R7", "first readback", so, 0);
    chk(user_q == 8'hA5, "R7", "write with pause", user_q, 8'hA5);
    dr_scan(8'h3C, 8, 0, so);
    chk(so == 8'hA5, "R7", "readback", so, 8'hA5);
    chk(user_q == 8'h3C, "R7", "rewrite", user_q, 8'h3C);

    ir_scan(8'hFF, so);
    dr_scan(8'hFF, 8, 0, so);
    chk(user_q == 8'h3C, "R7", "untouched under bypass", user_q, 8'h3C);

    ir_scan(8'h05, so);
    cyc(1, 0); cyc(0, 0); cyc(0, 1);
    for (int i = 0; i < 5; i++) cyc(1, 1);
    chk(tap_state_o == 0, "R3", "five ones", tap_state_o, 0);
    chk(ir_q == 8'hFF, "R5", "reset instr", ir_q, 8'hFF);

    cyc(0, 0); cyc(1, 0); cyc(1, 0); cyc(0, 0); cyc(0, 1);
    chk(tdo_oe == 1, "R8", "shift-ir enable", tdo_oe, 1);
    trst = 1;
    cyc(0, 1);
    chk(tap_state_o == 0 && tdo_oe == 0, "R2", "reset mid shift",
        {tap_state_o, tdo_oe}, 0);
    trst = 0;
    cyc(0, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule